// File: doc/BRIEF.md
# ADC Conversion Status Flag Controller

This block holds the result registers and status flags of an eight-channel, ten-bit sequential converter. An abstract converter model drives it. The model pulses a start request with a channel number. Later it pulses an end-of-conversion strobe that carries the channel number and the result. Each accepted result is written twice: into that channel's own result register, and into a shared "latest result" register that also records the channel number.

Software sees the block through a small register bus. Reads of the status word, the latest-result register and the per-channel result registers have side effects: they clear flags. Writes switch channels on and off. The block keeps these flags:

- a completion flag per channel;
- an overrun flag per channel;
- a global "new data" flag;
- a global overrun flag.

The block defines every flag outcome for the case where a bus read, or a channel switch-off, lands in the same clock cycle as an end of conversion. A sleep request and a converter-idle indication are also provided, so that power-down can start as soon as no conversion is in flight.

Top module: `adc_flag_ctrl`

## Requirements
- R1: After a synchronous reset, every flag, every enable bit, the latest-result register and every per-channel result register are zero, and `conv_idle` is 1.
- R2: An accepted end of conversion on channel c does all of the following:
  - stores the result in the result register of channel c, at address 8+c;
  - stores it in the latest-result register, at address 1, with the layout: bits 9:0 result, bits 14:12 channel, bit 15 valid;
  - sets completion flag c and the new-data flag.
  The status word is at address 0. Its bits 7:0 are the completion flags, bits 15:8 the per-channel overrun flags, bit 16 the new-data flag and bit 17 the global overrun flag.
- R3: Reading result register i clears completion flag i only. Reading the latest-result register clears the completion flag of the channel it holds, and clears the new-data flag. A same-cycle end of conversion on another channel neither redirects these clears nor is affected by them.
- R4: When a read clears a flag bit in the same cycle that an end of conversion sets it, the bit ends up set.
- R5: An end of conversion that finds the new-data flag set sets the global overrun flag. This happens even when the same cycle carries a read of another channel's result register or a switch-off of another channel. It does not happen when the same cycle carries a read of the latest-result register.
- R6: An end of conversion on channel c that finds completion flag c set, and not cleared in that cycle, sets overrun flag c.
- R7: Reading the status word clears all per-channel overrun flags and the global overrun flag. This holds when a same-cycle end of conversion sets a completion flag. An overrun raised by that same end of conversion remains set.
- R8: An end of conversion changes no flag and no register in either of these cases:
  - its channel is disabled, including a disable written in the same cycle;
  - its channel was disabled at any time while its conversion ran, even if it was enabled again afterwards.
- R9: A write to address 3 sets the enable bits given in `wdata`. A write to address 4 clears them. A read of address 2 returns the enable mask. A start request on a disabled channel is ignored.
- R10: `conv_idle` is 0 from the cycle after an accepted start request up to and including the end-of-conversion cycle. `sleep_on` follows `sleep_req` in the same cycle whenever no conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Converter begins a conversion |
| conv_chan | input | 3 | Channel of the starting conversion |
| eoc_valid | input | 1 | End-of-conversion strobe |
| eoc_chan | input | 3 | Channel of the finished conversion |
| eoc_data | input | 10 | Conversion result |
| sleep_req | input | 1 | Request to power the converter down |
| conv_idle | output | 1 | No conversion is in flight |
| sleep_on | output | 1 | Power-down is in effect |
| rd_en | input | 1 | Bus read strobe (side effects at the clock edge) |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Channel mask for enable writes |
| rdata | output | 32 | Read data, combinational from address |

## Verification
The two activities that collide are bus access and the converter's end-of-conversion strobe. The bus access is either a flag-clearing read or a channel-disable write. Each scenario task raises the strobe in exactly the cycle where it places a read of another channel, the same channel, the latest-result register or the status word, or a disable of the converting channel or an unrelated one. The flag state is then read back through the status word, one cycle later. It is compared against the outcome that follows from the set-wins and clear-only-the-named-bit rules.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;

    localparam int NCH_DEF      = 8;
    localparam int DW_DEF       = 10;
    localparam int RW_DEF       = 32;
    localparam int LAST_CH_LSB  = 12;
    localparam int LAST_VLD_BIT = 15;

    // Control register indices (low address bits, data region bit clear)
    typedef enum logic [2:0] {
        REG_STAT   = 3'd0,
        REG_LAST   = 3'd1,
        REG_ENMASK = 3'd2,
        REG_ENSET  = 3'd3,
        REG_ENCLR  = 3'd4
    } ctl_reg_e;

    typedef struct packed {
        logic stat_rd;
        logic last_rd;
        logic data_rd;
        logic mask_rd;
        logic en_set;
        logic en_clr;
    } bus_cmd_t;

    function automatic logic is_ctl(input logic [2:0] idx, input ctl_reg_e r);
        return idx == r;
    endfunction

endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
    import adc_flag_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int CHW = $clog2(NCH),
    parameter int AW  = CHW + 1
) (
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    output bus_cmd_t       cmd,
    output logic [CHW-1:0] data_ch
);
    logic       in_data;
    logic [2:0] ctl_idx;

    assign in_data = addr[AW-1];
    assign data_ch = addr[CHW-1:0];
    assign ctl_idx = 3'(addr[CHW-1:0]);

    always_comb begin
        cmd         = '0;
        cmd.data_rd = rd_en && in_data;
        cmd.stat_rd = rd_en && !in_data && is_ctl(ctl_idx, REG_STAT);
        cmd.last_rd = rd_en && !in_data && is_ctl(ctl_idx, REG_LAST);
        cmd.mask_rd = rd_en && !in_data && is_ctl(ctl_idx, REG_ENMASK);
        cmd.en_set  = wr_en && !in_data && is_ctl(ctl_idx, REG_ENSET);
        cmd.en_clr  = wr_en && !in_data && is_ctl(ctl_idx, REG_ENCLR);
    end
endmodule

// File: rtl/adc_conv_track.sv
module adc_conv_track #(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_set,
    input  logic           en_clr,
    input  logic [NCH-1:0] wmask,
    input  logic           conv_start,
    input  logic [CHW-1:0] conv_chan,
    input  logic           eoc_valid,
    input  logic [CHW-1:0] eoc_chan,
    input  logic           sleep_req,
    output logic [NCH-1:0] en_q,
    output logic           accept,
    output logic           busy_q,
    output logic           sleep_on
);
    logic [NCH-1:0] set_m, clr_m, en_next;
    logic [CHW-1:0] run_ch_q;
    logic           kill_q;
    logic           start_ok;
    logic           run_killed;

    assign set_m   = en_set ? wmask : '0;
    assign clr_m   = en_clr ? wmask : '0;
    assign en_next = (en_q | set_m) & ~clr_m;

    assign start_ok   = conv_start && en_next[conv_chan];
    assign run_killed = busy_q && kill_q && (run_ch_q == eoc_chan);
    assign accept     = eoc_valid && en_next[eoc_chan] && !run_killed;
    assign sleep_on   = sleep_req && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            busy_q   <= 1'b0;
            kill_q   <= 1'b0;
            run_ch_q <= '0;
        end else begin
            en_q <= en_next;
            if (start_ok) begin
                busy_q   <= 1'b1;
                kill_q   <= 1'b0;
                run_ch_q <= conv_chan;
            end else if (eoc_valid) begin
                busy_q <= 1'b0;
                kill_q <= 1'b0;
            end else if (busy_q && clr_m[run_ch_q]) begin
                kill_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
    parameter int NCH = 8,
    parameter int DW  = 10,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic [CHW-1:0] eoc_chan,
    input  logic [DW-1:0]  eoc_data,
    input  logic [CHW-1:0] rd_ch,
    output logic [DW-1:0]  rd_data,
    output logic [DW-1:0]  last_data,
    output logic [CHW-1:0] last_ch,
    output logic           last_vld
);
    logic [DW-1:0] chan_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst)
                chan_q[g] <= '0;
            else if (accept && (eoc_chan == CHW'(g)))
                chan_q[g] <= eoc_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_data <= '0;
            last_ch   <= '0;
            last_vld  <= 1'b0;
        end else if (accept) begin
            last_data <= eoc_data;
            last_ch   <= eoc_chan;
            last_vld  <= 1'b1;
        end
    end

    assign rd_data = chan_q[rd_ch];
endmodule

// File: rtl/adc_flag_core.sv
module adc_flag_core #(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stat_rd,
    input  logic           last_rd,
    input  logic           data_rd,
    input  logic [CHW-1:0] data_ch,
    input  logic [CHW-1:0] last_ch,
    input  logic           last_vld,
    input  logic           accept,
    input  logic [CHW-1:0] eoc_chan,
    output logic [NCH-1:0] done_q,
    output logic [NCH-1:0] ovr_q,
    output logic           drdy_q,
    output logic           govr_q
);
    localparam logic [NCH-1:0] ONE = NCH'(1);

    logic [NCH-1:0] clr_m, set_m, ovr_set;
    logic           drdy_clr;

    always_comb begin
        clr_m = '0;
        if (data_rd)
            clr_m = ONE << data_ch;
        else if (last_rd && last_vld)
            clr_m = ONE << last_ch;
    end

    assign set_m    = accept ? (ONE << eoc_chan) : '0;
    assign ovr_set  = set_m & done_q & ~clr_m;
    assign drdy_clr = last_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
            ovr_q  <= '0;
            drdy_q <= 1'b0;
            govr_q <= 1'b0;
        end else begin
            done_q <= (done_q & ~clr_m) | set_m;
            ovr_q  <= (stat_rd ? '0 : ovr_q) | ovr_set;
            drdy_q <= (drdy_q && !drdy_clr) || accept;
            govr_q <= (govr_q && !stat_rd) || (accept && drdy_q && !drdy_clr);
        end
    end
endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl
    import adc_flag_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int DW  = DW_DEF,
    parameter int RW  = RW_DEF,
    parameter int CHW = $clog2(NCH),
    parameter int AW  = CHW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           conv_start,
    input  logic [CHW-1:0] conv_chan,
    input  logic           eoc_valid,
    input  logic [CHW-1:0] eoc_chan,
    input  logic [DW-1:0]  eoc_data,
    input  logic           sleep_req,
    output logic           conv_idle,
    output logic           sleep_on,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [NCH-1:0] wdata,
    output logic [RW-1:0]  rdata
);
    bus_cmd_t       cmd;
    logic [CHW-1:0] data_ch;
    logic [NCH-1:0] en_q;
    logic           accept;
    logic           busy_q;
    logic [DW-1:0]  rd_data;
    logic [DW-1:0]  last_data;
    logic [CHW-1:0] last_ch;
    logic           last_vld;
    logic [NCH-1:0] done_q;
    logic [NCH-1:0] ovr_q;
    logic           drdy_q;
    logic           govr_q;

    adc_bus_decode #(.NCH(NCH), .CHW(CHW), .AW(AW)) u_dec (
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .cmd     (cmd),
        .data_ch (data_ch)
    );

    adc_conv_track #(.NCH(NCH), .CHW(CHW)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .en_set     (cmd.en_set),
        .en_clr     (cmd.en_clr),
        .wmask      (wdata),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .eoc_valid  (eoc_valid),
        .eoc_chan   (eoc_chan),
        .sleep_req  (sleep_req),
        .en_q       (en_q),
        .accept     (accept),
        .busy_q     (busy_q),
        .sleep_on   (sleep_on)
    );

    adc_result_store #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_res (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .eoc_chan  (eoc_chan),
        .eoc_data  (eoc_data),
        .rd_ch     (data_ch),
        .rd_data   (rd_data),
        .last_data (last_data),
        .last_ch   (last_ch),
        .last_vld  (last_vld)
    );

    adc_flag_core #(.NCH(NCH), .CHW(CHW)) u_flg (
        .clk      (clk),
        .rst      (rst),
        .stat_rd  (cmd.stat_rd),
        .last_rd  (cmd.last_rd),
        .data_rd  (cmd.data_rd),
        .data_ch  (data_ch),
        .last_ch  (last_ch),
        .last_vld (last_vld),
        .accept   (accept),
        .eoc_chan (eoc_chan),
        .done_q   (done_q),
        .ovr_q    (ovr_q),
        .drdy_q   (drdy_q),
        .govr_q   (govr_q)
    );

    assign conv_idle = !busy_q;

    always_comb begin
        rdata = '0;
        if (cmd.stat_rd) begin
            rdata[NCH-1:0]     = done_q;
            rdata[2*NCH-1:NCH] = ovr_q;
            rdata[2*NCH]       = drdy_q;
            rdata[2*NCH+1]     = govr_q;
        end else if (cmd.last_rd) begin
            rdata[DW-1:0]              = last_data;
            rdata[LAST_CH_LSB +: CHW]  = last_ch;
            rdata[LAST_VLD_BIT]        = last_vld;
        end else if (cmd.mask_rd) begin
            rdata[NCH-1:0] = en_q;
        end else if (cmd.data_rd) begin
            rdata[DW-1:0] = rd_data;
        end
    end
endmodule

// File: rtl/adc_flag_sva.sv
module adc_flag_sva #(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH),
    parameter int AW  = CHW + 1
) (
    input logic           clk,
    input logic           rst,
    input logic           rd_en,
    input logic           wr_en,
    input logic [AW-1:0]  addr,
    input logic           eoc_valid,
    input logic [CHW-1:0] eoc_chan,
    input logic           accept,
    input logic [NCH-1:0] done,
    input logic [NCH-1:0] ovr,
    input logic           drdy,
    input logic           govr,
    input logic [NCH-1:0] en,
    input logic [CHW-1:0] last_ch,
    input logic           last_vld
);
    logic stat_rd_c, last_rd_c, own_data_rd_c, own_last_rd_c;

    assign stat_rd_c     = rd_en && (addr == AW'(0));
    assign last_rd_c     = rd_en && (addr == AW'(1));
    assign own_data_rd_c = rd_en && (addr == {1'b1, eoc_chan});
    assign own_last_rd_c = last_rd_c && last_vld && (last_ch == eoc_chan);

    a_r2_eoc_sets_flags: assert property (@(posedge clk) disable iff (rst)
        accept |=> drdy && done[$past(eoc_chan)]);

    a_r3_clear_only_target: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[AW-1] && !eoc_valid) |=>
        (done == ($past(done) & ~(NCH'(1) << $past(addr[CHW-1:0])))));

    a_r4_set_beats_read: assert property (@(posedge clk) disable iff (rst)
        (accept && own_data_rd_c) |=> done[$past(eoc_chan)]);

    a_r5_global_overrun: assert property (@(posedge clk) disable iff (rst)
        (accept && drdy && !last_rd_c) |=> govr);

    a_r6_chan_overrun: assert property (@(posedge clk) disable iff (rst)
        (accept && done[eoc_chan] && !own_data_rd_c && !own_last_rd_c) |=>
        ovr[$past(eoc_chan)]);

    a_r7_status_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_c && !eoc_valid) |=> (ovr == '0) && !govr);

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (eoc_valid && !en[eoc_chan] && !wr_en && !rd_en) |=>
        $stable(done) && $stable(ovr) && $stable(drdy) && $stable(govr));
endmodule

bind adc_flag_ctrl adc_flag_sva #(.NCH(NCH), .CHW(CHW), .AW(AW)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .eoc_valid (eoc_valid),
    .eoc_chan  (eoc_chan),
    .accept    (accept),
    .done      (done_q),
    .ovr       (ovr_q),
    .drdy      (drdy_q),
    .govr      (govr_q),
    .en        (en_q),
    .last_ch   (last_ch),
    .last_vld  (last_vld)
);

// File: tb/sim_adc_flag_ctrl.sv
module sim_adc_flag_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_start = 1'b0;
    logic [2:0]  conv_chan = '0;
    logic        eoc_valid = 1'b0;
    logic [2:0]  eoc_chan = '0;
    logic [9:0]  eoc_data = '0;
    logic        sleep_req = 1'b0;
    logic        conv_idle, sleep_on;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    adc_flag_ctrl u0 (
        .clk(clk), .rst(rst), .conv_start(conv_start), .conv_chan(conv_chan),
        .eoc_valid(eoc_valid), .eoc_chan(eoc_chan), .eoc_data(eoc_data),
        .sleep_req(sleep_req), .conv_idle(conv_idle), .sleep_on(sleep_on),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] m);
        wr_en = 1'b1; addr = a; wdata = m;
        cyc();
        wr_en = 1'b0;
    endtask

    // side: 0 none, 1 read at sa, 2 write sw to sa -- both in the eoc cycle
    task automatic conv(input int ch, input int d, input int side,
                        input logic [3:0] sa, input logic [7:0] sw,
                        output logic [31:0] srd);
        conv_start = 1'b1; conv_chan = 3'(ch);
        cyc();
        conv_start = 1'b0;
        eoc_valid = 1'b1; eoc_chan = 3'(ch); eoc_data = 10'(d);
        if (side == 1) begin rd_en = 1'b1; addr = sa; end
        if (side == 2) begin wr_en = 1'b1; addr = sa; wdata = sw; end
        #1 srd = rdata;
        cyc();
        eoc_valid = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v);  chk("R1 status after reset", v, 32'h0);
        rd(4'd2, v);  chk("R1 enable mask after reset", v, 32'h0);
        rd(4'd1, v);  chk("R1 latest result after reset", v, 32'h0);
        rd(4'd12, v); chk("R1 channel 4 result after reset", v, 32'h0);
        chk("R1 conv_idle after reset", 32'(conv_idle), 32'h1);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(4'd3, 8'hFF);
        wr(4'd4, 8'h80);
        rd(4'd2, v); chk("R9 enable mask after set/clear", v, 32'h7F);
    endtask

    task automatic t_basic_sleep();
        logic [31:0] v;
        sleep_req = 1'b1;
        #1 chk("R10 sleep_on while idle", 32'(sleep_on), 32'h1);
        conv_start = 1'b1; conv_chan = 3'd1;
        cyc();
        conv_start = 1'b0;
        chk("R10 conv_idle during conversion", 32'(conv_idle), 32'h0);
        chk("R10 sleep_on held off while busy", 32'(sleep_on), 32'h0);
        eoc_valid = 1'b1; eoc_chan = 3'd1; eoc_data = 10'h2A5;
        cyc();
        eoc_valid = 1'b0;
        chk("R10 conv_idle after eoc", 32'(conv_idle), 32'h1);
        chk("R10 sleep_on right after eoc", 32'(sleep_on), 32'h1);
        sleep_req = 1'b0;
        rd(4'd0, v); chk("R2 status after one result", v, 32'h10002);
        rd(4'd9, v); chk("R2 channel 1 result", v, 32'h2A5);
        rd(4'd0, v); chk("R3 result read clears own done", v, 32'h10000);
        rd(4'd1, v); chk("R2 latest result fields", v, 32'h92A5);
        rd(4'd0, v); chk("R3 latest read clears new-data", v, 32'h0);
        conv_start = 1'b1; conv_chan = 3'd7;
        cyc();
        conv_start = 1'b0;
        chk("R9 start on disabled channel ignored", 32'(conv_idle), 32'h1);
    endtask

    task automatic t_read_collide();
        logic [31:0] v, s;
        conv(2, 'h111, 0, 4'd0, 8'h0, s);
        conv(3, 'h0CC, 1, 4'd10, 8'h0, s);
        chk("R3 read of ch2 during ch3 eoc returns data", s, 32'h111);
        rd(4'd0, v); chk("R3/R5 clear lands on ch2, govr set", v, 32'h30008);
        rd(4'd0, v); chk("R7 status read cleared govr", v, 32'h10008);
        rd(4'd1, v); chk("R2 latest holds ch3", v, 32'hB0CC);
        rd(4'd0, v); chk("R3 status clean", v, 32'h0);
        conv(1, 'h155, 0, 4'd0, 8'h0, s);
        conv(2, 'h2AA, 1, 4'd1, 8'h0, s);
        chk("R3 latest read during eoc returns old", s, 32'h9155);
        rd(4'd0, v); chk("R3/R5 latest read clears ch1 only, no govr", v, 32'h10004);
        rd(4'd1, v); chk("R2 latest holds ch2", v, 32'hA2AA);
        rd(4'd0, v); chk("R3 status clean again", v, 32'h0);
    endtask

    task automatic t_same_chan();
        logic [31:0] v, s;
        conv(0, 'h001, 0, 4'd0, 8'h0, s);
        conv(0, 'h002, 1, 4'd8, 8'h0, s);
        chk("R4 old ch0 data read", s, 32'h001);
        rd(4'd0, v); chk("R4 done kept, no ch overrun", v, 32'h30001);
        rd(4'd0, v); chk("R7 govr cleared", v, 32'h10001);
        conv(0, 'h003, 0, 4'd0, 8'h0, s);
        rd(4'd0, v); chk("R6 ch0 overrun set", v, 32'h30101);
        rd(4'd0, v); chk("R7 ch0 overrun cleared", v, 32'h10001);
        rd(4'd1, v); chk("R2 latest ch0", v, 32'h8003);
        rd(4'd0, v); chk("R3 status clean", v, 32'h0);
    endtask

    task automatic t_status_collide();
        logic [31:0] v, s;
        conv(1, 'h010, 0, 4'd0, 8'h0, s);
        conv(1, 'h011, 0, 4'd0, 8'h0, s);
        conv(2, 'h020, 1, 4'd0, 8'h0, s);
        chk("R6 status seen during eoc", s, 32'h30202);
        rd(4'd0, v); chk("R7/R4 ovr1 cleared, new govr kept", v, 32'h30006);
        rd(4'd0, v); chk("R7 govr cleared", v, 32'h10006);
        rd(4'd9, v); chk("R2 ch1 latest data", v, 32'h011);
        rd(4'd10, v); chk("R2 ch2 data", v, 32'h020);
        rd(4'd1, v); chk("R2 latest ch2", v, 32'hA020);
        rd(4'd0, v); chk("R3 status clean", v, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] v, s;
        conv_start = 1'b1; conv_chan = 3'd2;
        cyc();
        conv_start = 1'b0;
        wr(4'd4, 8'h04);
        wr(4'd3, 8'h04);
        eoc_valid = 1'b1; eoc_chan = 3'd2; eoc_data = 10'h3FF;
        cyc();
        eoc_valid = 1'b0;
        chk("R10 idle after killed conversion", 32'(conv_idle), 32'h1);
        rd(4'd0, v);  chk("R8 killed conversion raises nothing", v, 32'h0);
        rd(4'd10, v); chk("R8 ch2 data unchanged", v, 32'h020);
        conv(2, 'h3FE, 2, 4'd4, 8'h04, s);
        rd(4'd0, v);  chk("R8 same-cycle disable suppresses eoc", v, 32'h0);
        rd(4'd1, v);  chk("R8 latest unchanged", v, 32'hA020);
        eoc_valid = 1'b1; eoc_chan = 3'd7; eoc_data = 10'h155;
        cyc();
        eoc_valid = 1'b0;
        rd(4'd0, v);  chk("R8 eoc on disabled ch7 ignored", v, 32'h0);
        rd(4'd15, v); chk("R8 ch7 data untouched", v, 32'h0);
        wr(4'd3, 8'h04);
        conv(0, 'h005, 0, 4'd0, 8'h0, s);
        conv(1, 'h006, 2, 4'd4, 8'h08, s);
        rd(4'd0, v); chk("R5 disable of ch3 keeps govr", v, 32'h30003);
        rd(4'd2, v); chk("R9 ch3 disabled", v, 32'h77);
        rd(4'd8, v); rd(4'd9, v); rd(4'd1, v);
        chk("R2 latest ch1", v, 32'h9006);
        rd(4'd0, v); chk("R3 status clean", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc();
        t_reset();
        t_enable();
        t_basic_sleep();
        t_read_collide();
        t_same_chan();
        t_status_collide();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule